// File: doc/BRIEF.md
# Prescaled 32-bit Capture/Compare Timer

This block is a 32-bit up-counter with its own small register file on a simple single-cycle register bus. Its count clock is an enable derived from one of two sources: the system clock, passed straight through or slowed by a fixed divide-by-16, or the rising edges of an asynchronous external clock input. Either source then feeds an 8-bit programmable prescaler, and the counter advances once each time the prescaler wraps.

Two operating modes share the counter. In compare mode the counter is compared against a programmed reference value. A match toggles the timer output or pulses it for one clock, and can restart the count at zero. In capture mode a chosen edge of an asynchronous capture input copies the running count into a capture register. Both inputs are synchronized with two flops before their edges are taken.

Each match or capture sets an event flag. Depending on the configuration, the flag drives a level interrupt or raises a DMA request, which stays high until it is acknowledged.

Top module: `cct_timer`

## Requirements
- R1: After reset, every readable register reads zero and `tmr_out`, `irq` and `dma_req` are low. Word addresses are CTRL=0, CMP=1, CAP=2, CNT=3, STAT=4.
- R2: With CTRL[1]=0 and CTRL[2]=0, the counter advances once every P+1 system clocks while CTRL[0] (run) is 1. P is CTRL[23:16].
- R3: With CTRL[2]=1 (and CTRL[1]=0), the system clock is first divided by 16, so the counter advances once every 16*(P+1) clocks.
- R4: With CTRL[1]=1, the counter advances once per P+1 synchronized rising edges of `ext_clk`, and system clocks alone do not advance it.
- R5: While run is 0 the counter holds its value. A bus write to CNT loads the counter with the written data.
- R6: In compare mode (CTRL[3]=0), a match is a counter advance taken while the count equals CMP. On a match, CTRL[7]=1 makes the next count zero; with CTRL[7]=0 counting continues upward.
- R7: On a match, `tmr_out` toggles when CTRL[6]=0. When CTRL[6]=1, it is high for exactly the one clock after the match.
- R8: In capture mode (CTRL[3]=1), CTRL[5:4] selects the edge of synchronized `cap_in`: 00 none, 01 rising, 10 falling, 11 both. A selected edge copies the count into CAP. Unselected edges change nothing, and compare matches produce no event.
- R9: A match or capture sets STAT[0]. Writing 1 to STAT[0] clears it, writing 0 leaves it, and a new event in the same cycle wins over the clear.
- R10: `irq` is high while STAT[0] is set, CTRL[8] (event enable) is 1 and CTRL[9] (DMA routing) is 0.
- R11: With CTRL[8]=1 and CTRL[9]=1, an event raises `dma_req` and `irq` stays low. `dma_req` stays high until `dma_ack`, and the acknowledge clears both `dma_req` and STAT[0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | Write qualifier for the strobe |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| ext_clk | input | 1 | Asynchronous external count clock |
| cap_in | input | 1 | Asynchronous capture input |
| tmr_out | output | 1 | Compare output |
| irq | output | 1 | Level interrupt request |
| dma_req | output | 1 | DMA request, held until acknowledged |
| dma_ack | input | 1 | DMA acknowledge |

## Verification
The assertions assume that `ext_clk` and `cap_in` hold each level across at least two rising clock edges, so that every edge reaches the synchronized level. They also assume that `dma_ack` is raised for single cycles while a request is pending, and that bus writes last exactly one strobed cycle. The stimulus keeps every external level for three or more clocks. It pulses the acknowledge for one clock only after it has seen the request, and it issues every register write through one task that holds the strobe for a single edge. Prescaler and source changes are made only while the timer is stopped, so that no count window straddles a reconfiguration.

// File: rtl/cct_pkg.sv
package cct_pkg;

  // register word addresses
  localparam int unsigned A_CTRL = 0;
  localparam int unsigned A_CMP  = 1;
  localparam int unsigned A_CAP  = 2;
  localparam int unsigned A_CNT  = 3;
  localparam int unsigned A_STAT = 4;

  // control bit positions
  localparam int B_RUN   = 0;
  localparam int B_EXT   = 1;
  localparam int B_SLOW  = 2;
  localparam int B_CAPM  = 3;
  localparam int B_EDGE  = 4;
  localparam int B_PULSE = 6;
  localparam int B_RST   = 7;
  localparam int B_EN    = 8;
  localparam int B_DMA   = 9;
  localparam int B_PSC   = 16;
  localparam int FLAG_W  = 10;

  typedef enum logic [1:0] {
    TRIG_NONE = 2'b00,
    TRIG_RISE = 2'b01,
    TRIG_FALL = 2'b10,
    TRIG_BOTH = 2'b11
  } trig_e;

  typedef struct packed {
    logic  run;
    logic  src_ext;
    logic  slow;
    logic  cap_mode;
    trig_e trig;
    logic  pulse;
    logic  restart;
    logic  evt_en;
    logic  evt_dma;
  } ctrl_t;

  function automatic ctrl_t ctrl_decode(input logic [FLAG_W-1:0] r);
    ctrl_t c;
    c.run      = r[B_RUN];
    c.src_ext  = r[B_EXT];
    c.slow     = r[B_SLOW];
    c.cap_mode = r[B_CAPM];
    c.trig     = trig_e'(r[B_EDGE +: 2]);
    c.pulse    = r[B_PULSE];
    c.restart  = r[B_RST];
    c.evt_en   = r[B_EN];
    c.evt_dma  = r[B_DMA];
    return c;
  endfunction

endpackage

// File: rtl/cct_sync.sv
module cct_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic lvl_now,
  output logic lvl_prev
);
  // STAGES synchronizer flops plus one history flop
  logic [STAGES:0] sh_q, sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-1:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign lvl_now  = sh_q[STAGES-1];
  assign lvl_prev = sh_q[STAGES];
endmodule

// File: rtl/cct_tick_gen.sv
module cct_tick_gen #(
  parameter int PSC_W    = 8,
  parameter int SLOW_DIV = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             src_ext,
  input  logic             slow,
  input  logic [PSC_W-1:0] psc,
  input  logic             ext_now,
  input  logic             ext_prev,
  output logic             tick
);
  localparam int DW = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;
  localparam logic [DW-1:0] DIV_LAST = DW'(SLOW_DIV - 1);

  logic [DW-1:0]    div_q, div_d;
  logic [PSC_W-1:0] pre_q, pre_d;
  logic             base, ext_rise, pre_wrap;

  always_comb begin
    ext_rise = ext_now & ~ext_prev;
    if (src_ext)   base = ext_rise;
    else if (slow) base = (div_q == DIV_LAST);
    else           base = 1'b1;

    if (!run || src_ext || !slow) div_d = '0;
    else if (div_q == DIV_LAST)   div_d = '0;
    else                          div_d = div_q + DW'(1);

    pre_wrap = (pre_q >= psc);
    if (!run)          pre_d = '0;
    else if (!base)    pre_d = pre_q;
    else if (pre_wrap) pre_d = '0;
    else               pre_d = pre_q + PSC_W'(1);

    tick = run & base & pre_wrap;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      pre_q <= '0;
    end else begin
      div_q <= div_d;
      pre_q <= pre_d;
    end
  end
endmodule

// File: rtl/cct_core.sv
module cct_core
  import cct_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             cap_mode,
  input  trig_e            trig,
  input  logic             pulse,
  input  logic             restart,
  input  logic [CNT_W-1:0] cmp_val,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_wdata,
  input  logic             cap_now,
  input  logic             cap_prev,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] cap,
  output logic             tout,
  output logic             hit,
  output logic             cap_hit,
  output logic             evt
);
  logic [CNT_W-1:0] cnt_q, cnt_d, cap_q, cap_d;
  logic             tout_q, tout_d;
  logic             rise, fall, want_rise, want_fall;

  always_comb begin
    rise      = cap_now & ~cap_prev;
    fall      = ~cap_now & cap_prev;
    want_rise = (trig == TRIG_RISE) || (trig == TRIG_BOTH);
    want_fall = (trig == TRIG_FALL) || (trig == TRIG_BOTH);
    cap_hit   = cap_mode && ((want_rise && rise) || (want_fall && fall));
    hit       = !cap_mode && tick && (cnt_q == cmp_val);
    evt       = hit | cap_hit;

    if (cnt_wr)              cnt_d = cnt_wdata;
    else if (hit && restart) cnt_d = '0;
    else if (tick)           cnt_d = cnt_q + CNT_W'(1);
    else                     cnt_d = cnt_q;

    cap_d = cap_hit ? cnt_q : cap_q;

    if (pulse)    tout_d = hit;
    else if (hit) tout_d = ~tout_q;
    else          tout_d = tout_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      cap_q  <= '0;
      tout_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      cap_q  <= cap_d;
      tout_q <= tout_d;
    end
  end

  assign cnt  = cnt_q;
  assign cap  = cap_q;
  assign tout = tout_q;
endmodule

// File: rtl/cct_timer.sv
module cct_timer
  import cct_pkg::*;
#(
  parameter int CNT_W       = 32,
  parameter int PSC_W       = 8,
  parameter int SLOW_DIV    = 16,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  input  logic              ext_clk,
  input  logic              cap_in,
  output logic              tmr_out,
  output logic              irq,
  output logic              dma_req,
  input  logic              dma_ack
);
  localparam int N_ASYNC = 2;  // index 0: capture input, 1: external clock

  // reset: asynchronous assert, synchronous release
  logic [1:0] rs_q;
  logic       rst_sn;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sn = rs_q[1];

  // input synchronizers
  logic [N_ASYNC-1:0] async_in, lvl_now, lvl_prev;
  assign async_in = {ext_clk, cap_in};
  for (genvar g = 0; g < N_ASYNC; g++) begin : g_sync
    cct_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_sn),
      .din      (async_in[g]),
      .lvl_now  (lvl_now[g]),
      .lvl_prev (lvl_prev[g])
    );
  end

  // register file state
  logic [FLAG_W-1:0] flags_q, flags_d;
  logic [PSC_W-1:0]  psc_q, psc_d;
  logic [CNT_W-1:0]  cmp_q, cmp_d;
  logic              flag_q, flag_d, dma_q, dma_d;
  ctrl_t             c;
  logic              wr_en, wr_ctrl, wr_cmp, wr_cnt, wr_stat;

  assign c       = ctrl_decode(flags_q);
  assign wr_en   = bus_sel & bus_wr;
  assign wr_ctrl = wr_en && (bus_addr == ADDR_W'(A_CTRL));
  assign wr_cmp  = wr_en && (bus_addr == ADDR_W'(A_CMP));
  assign wr_cnt  = wr_en && (bus_addr == ADDR_W'(A_CNT));
  assign wr_stat = wr_en && (bus_addr == ADDR_W'(A_STAT));

  // count clock enable
  logic tick;
  cct_tick_gen #(.PSC_W(PSC_W), .SLOW_DIV(SLOW_DIV)) u_tick (
    .clk      (clk),
    .rst_n    (rst_sn),
    .run      (c.run),
    .src_ext  (c.src_ext),
    .slow     (c.slow),
    .psc      (psc_q),
    .ext_now  (lvl_now[1]),
    .ext_prev (lvl_prev[1]),
    .tick     (tick)
  );

  // counter, compare and capture
  logic [CNT_W-1:0] cnt, cap;
  logic             hit, cap_hit, evt;
  cct_core #(.CNT_W(CNT_W)) u_core (
    .clk       (clk),
    .rst_n     (rst_sn),
    .tick      (tick),
    .cap_mode  (c.cap_mode),
    .trig      (c.trig),
    .pulse     (c.pulse),
    .restart   (c.restart),
    .cmp_val   (cmp_q),
    .cnt_wr    (wr_cnt),
    .cnt_wdata (bus_wdata),
    .cap_now   (lvl_now[0]),
    .cap_prev  (lvl_prev[0]),
    .cnt       (cnt),
    .cap       (cap),
    .tout      (tmr_out),
    .hit       (hit),
    .cap_hit   (cap_hit),
    .evt       (evt)
  );

  // next state of registers and event routing
  always_comb begin
    flags_d = flags_q;
    psc_d   = psc_q;
    cmp_d   = cmp_q;
    flag_d  = flag_q;
    dma_d   = dma_q;
    if (wr_ctrl) begin
      flags_d = bus_wdata[FLAG_W-1:0];
      psc_d   = bus_wdata[B_PSC +: PSC_W];
    end
    if (wr_cmp) cmp_d = bus_wdata;
    if (wr_stat && bus_wdata[0]) flag_d = 1'b0;
    if (dma_ack && dma_q) begin
      flag_d = 1'b0;
      dma_d  = 1'b0;
    end
    if (evt) begin
      flag_d = 1'b1;
      if (c.evt_en && c.evt_dma) dma_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      flags_q <= '0;
      psc_q   <= '0;
      cmp_q   <= '0;
      flag_q  <= 1'b0;
      dma_q   <= 1'b0;
    end else begin
      flags_q <= flags_d;
      psc_q   <= psc_d;
      cmp_q   <= cmp_d;
      flag_q  <= flag_d;
      dma_q   <= dma_d;
    end
  end

  // read mux
  always_comb begin
    case (bus_addr)
      ADDR_W'(A_CTRL): bus_rdata = (CNT_W'(psc_q) << B_PSC) | CNT_W'(flags_q);
      ADDR_W'(A_CMP):  bus_rdata = cmp_q;
      ADDR_W'(A_CAP):  bus_rdata = cap;
      ADDR_W'(A_CNT):  bus_rdata = cnt;
      ADDR_W'(A_STAT): bus_rdata = CNT_W'(flag_q);
      default:         bus_rdata = '0;
    endcase
  end

  assign irq     = flag_q & c.evt_en & ~c.evt_dma;
  assign dma_req = dma_q;
endmodule

// File: rtl/cct_timer_chk.sv
module cct_timer_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             run,
  input logic             cnt_wr,
  input logic             hit,
  input logic             restart,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] cap,
  input logic             cap_hit,
  input logic             evt,
  input logic             flag,
  input logic             dma_req,
  input logic             dma_ack
);
  // R2: an advance without load or restart adds one
  a_r2_advance: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !cnt_wr && !(hit && restart) |=> cnt == CNT_W'($past(cnt) + 1));

  // R4: count enables only appear while running
  a_r4_tick_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> run);

  // R5: no advance and no load means the count holds
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !tick && !cnt_wr |=> $stable(cnt));

  // R6: restart on match returns the count to zero
  a_r6_restart: assert property (@(posedge clk) disable iff (!rst_n)
    hit && restart && !cnt_wr |=> cnt == '0);

  // R8: the capture register changes only on a selected edge
  a_r8_cap_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_hit |=> $stable(cap));

  // R9: every event leaves the flag set
  a_r9_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> flag);

  // R11: a pending request stays until acknowledged
  a_r11_dma_hold: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req && !dma_ack |=> dma_req);

  // R11: an acknowledge without a new event drops the request
  a_r11_dma_clear: assert property (@(posedge clk) disable iff (!rst_n)
    dma_ack && !evt |=> !dma_req);
endmodule

bind cct_timer cct_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_sn),
  .tick    (tick),
  .run     (c.run),
  .cnt_wr  (wr_cnt),
  .hit     (hit),
  .restart (c.restart),
  .cnt     (cnt),
  .cap     (cap),
  .cap_hit (cap_hit),
  .evt     (evt),
  .flag    (flag_q),
  .dma_req (dma_req),
  .dma_ack (dma_ack)
);

// File: tb/sim_cct_timer.sv
`timescale 1ns/1ps
module sim_cct_timer;
  import cct_pkg::*;

  logic        clk, rst_n, bus_sel, bus_wr, ext_clk, cap_in, dma_ack;
  logic [2:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        tmr_out, irq, dma_req;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  cct_timer u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ext_clk(ext_clk), .cap_in(cap_in), .tmr_out(tmr_out), .irq(irq),
    .dma_req(dma_req), .dma_ack(dma_ack)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  // {slow, psc, idle cycles, expected count}; B = idle+1 enabled edges,
  // expected = floor(B / ((slow ? 16 : 1) * (psc + 1)))
  localparam logic [56:0] VEC [6] = '{
    {1'b0, 8'd0,   16'd9,   32'd10},
    {1'b0, 8'd3,   16'd19,  32'd5},
    {1'b0, 8'd255, 16'd599, 32'd2},
    {1'b1, 8'd0,   16'd49,  32'd3},
    {1'b1, 8'd2,   16'd199, 32'd4},
    {1'b0, 8'd1,   16'd0,   32'd0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // called just after a falling edge; the write happens on the next rising edge
  task automatic wr(input int unsigned a, input logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 3'(a); bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input int unsigned a, output logic [31:0] d);
    bus_addr = 3'(a);
    #1;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, d2;
    logic        t0;
    int          n;
    rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    ext_clk = 1'b0; cap_in = 1'b0; dma_ack = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(4);

    // R1 reset state
    for (int a = 0; a < 5; a++) begin
      rd(a, d);
      chk("R1 register reads zero", d, 32'h0);
    end
    chk("R1 outputs low", {29'h0, tmr_out, irq, dma_req}, 32'h0);

    // R2 / R3 vector table
    for (int i = 0; i < 6; i++) begin
      logic [56:0] v;
      v = VEC[i];
      wr(A_CNT, 32'h0);
      wr(A_CTRL, {8'h0, v[55:48], 13'h0, v[56], 1'b0, 1'b1});
      idle(int'(v[47:32]));
      wr(A_CTRL, 32'h0);
      rd(A_CNT, d);
      chk(v[56] ? "R3 slow prescaled count" : "R2 prescaled count", d, v[31:0]);
    end

    // R6 / R7 / R10 compare with restart, toggle output, interrupt
    wr(A_CNT, 32'h0);
    wr(A_CMP, 32'd5);
    wr(A_STAT, 32'h1);
    t0 = tmr_out;
    wr(A_CTRL, 32'h181);  // run | restart | event enable
    n = 0;
    while (!irq && n < 100) begin @(negedge clk); n++; end
    chk("R6 match after CMP+1 advances", n, 32'd6);
    chk("R10 irq on enabled event", {31'h0, irq}, 32'h1);
    chk("R7 toggle on first match", {31'h0, tmr_out}, {31'h0, ~t0});
    rd(A_CNT, d);
    chk("R6 restart to zero", d, 32'h0);
    n = 0;
    while (tmr_out == ~t0 && n < 100) begin @(negedge clk); n++; end
    chk("R7 toggle period with restart", n, 32'd6);
    wr(A_CTRL, 32'h0);

    // R9 status clear rules
    rd(A_STAT, d);
    chk("R9 flag set by match", d, 32'h1);
    wr(A_STAT, 32'h0);
    rd(A_STAT, d);
    chk("R9 write of zero leaves flag", d, 32'h1);
    wr(A_STAT, 32'h1);
    rd(A_STAT, d);
    chk("R9 write of one clears flag", d, 32'h0);

    // R6 / R7 no restart, pulse output
    wr(A_CNT, 32'h0);
    wr(A_CMP, 32'd3);
    wr(A_CTRL, 32'h141);  // run | pulse | event enable
    @(negedge clk);
    n = 1;
    while (!tmr_out && n < 100) begin @(negedge clk); n++; end
    chk("R7 pulse at match", n, 32'd4);
    @(negedge clk);
    chk("R7 pulse lasts one clock", {31'h0, tmr_out}, 32'h0);
    rd(A_CNT, d);
    chk("R6 count continues without restart", d, 32'd5);
    wr(A_CTRL, 32'h0);
    wr(A_STAT, 32'h1);

    // R8 / R10 capture edges, event enable off
    wr(A_CNT, 32'h1234);
    wr(A_CTRL, 32'h18);  // capture, rising
    cap_in = 1'b1; idle(5);
    rd(A_CAP, d);
    chk("R8 rising edge captures", d, 32'h1234);
    rd(A_STAT, d);
    chk("R9 capture sets flag", d, 32'h1);
    chk("R10 irq low with events disabled", {31'h0, irq}, 32'h0);
    wr(A_CNT, 32'h55);
    cap_in = 1'b0; idle(5);
    rd(A_CAP, d);
    chk("R8 falling edge ignored in rising mode", d, 32'h1234);
    wr(A_CTRL, 32'h28);  // capture, falling
    cap_in = 1'b1; idle(5);
    rd(A_CAP, d);
    chk("R8 rising edge ignored in falling mode", d, 32'h1234);
    cap_in = 1'b0; idle(5);
    rd(A_CAP, d);
    chk("R8 falling edge captures", d, 32'h55);
    wr(A_CTRL, 32'h38);  // capture, both
    wr(A_CNT, 32'h77);
    cap_in = 1'b1; idle(5);
    rd(A_CAP, d);
    chk("R8 both-edge mode captures", d, 32'h77);
    wr(A_CTRL, 32'h08);  // capture, none
    wr(A_CNT, 32'h99);
    cap_in = 1'b0; idle(5);
    rd(A_CAP, d);
    chk("R8 no edge selected holds", d, 32'h77);

    // R8 compare suppressed in capture mode
    wr(A_STAT, 32'h1);
    wr(A_CMP, 32'h0);
    wr(A_CNT, 32'h0);
    t0 = tmr_out;
    wr(A_CTRL, 32'h09);  // capture, run
    idle(20);
    rd(A_STAT, d);
    chk("R8 no compare event in capture mode", d, 32'h0);
    chk("R8 output unchanged in capture mode", {31'h0, tmr_out}, {31'h0, t0});
    wr(A_CTRL, 32'h08);

    // R11 DMA routing
    wr(A_STAT, 32'h1);
    wr(A_CTRL, 32'h318);  // capture rising, enable, route to DMA
    cap_in = 1'b1; idle(5);
    chk("R11 dma request raised", {31'h0, dma_req}, 32'h1);
    chk("R10 irq low when routed to DMA", {31'h0, irq}, 32'h0);
    idle(6);
    chk("R11 request held until ack", {31'h0, dma_req}, 32'h1);
    dma_ack = 1'b1;
    @(negedge clk);
    dma_ack = 1'b0;
    chk("R11 ack clears request", {31'h0, dma_req}, 32'h0);
    rd(A_STAT, d);
    chk("R11 ack clears flag", d, 32'h0);

    // R4 external clock with prescaler 1
    wr(A_CTRL, 32'h0);
    wr(A_CNT, 32'h0);
    wr(A_CTRL, 32'h0001_0003);  // run | external | psc=1
    for (int p = 0; p < 6; p++) begin
      ext_clk = 1'b1; idle(3);
      ext_clk = 1'b0; idle(3);
    end
    idle(5);
    wr(A_CTRL, 32'h0);
    rd(A_CNT, d);
    chk("R4 external edges through prescaler", d, 32'd3);

    // R5 hold while stopped
    idle(20);
    rd(A_CNT, d2);
    chk("R5 count holds while stopped", d2, d);
    wr(A_CNT, 32'hA5A5_0001);
    rd(A_CNT, d);
    chk("R5 write loads count", d, 32'hA5A5_0001);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule